// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Sequencer

This block sequences a single-channel 16-bit converter behind a read-only 3-wire serial port made of an active-low chip select, a host-driven serial clock and a three-state data line. It runs from a fast system clock that oversamples the two serial inputs through two-flop synchronizers and edge detectors. After power-on reset it starts a timed conversion, takes the code offered by the converter core on a valid strobe, clamps it to 16 bits, and then sleeps holding the result until the host asks for it.

The host reads by pulling chip select and the serial clock low together. The block then presents the most significant bit and moves one bit lower on every later falling clock edge. A frame ends on the sixteenth falling edge or is cut short by chip select going high. Either ending starts the next conversion, which no serial-pin activity can stop. While a conversion runs, an enabled output reads high as a busy flag; once the result is ready it reads low. The three-state driver is modelled as a data bit plus an output enable.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset is released the block holds in a power-on state for POR_CYC clock cycles with the output driver disabled, then starts a conversion, flagged by a one-cycle conv_start_o pulse; the phases then always run conversion, sleep, readout, conversion.
- R2: A conversion lasts CONV_CYC clock cycles, and no activity on chip select or the serial clock shortens or restarts it.
- R3: The block leaves sleep for readout only when the synchronized chip select and serial clock are both low; chip select low with the serial clock high keeps it asleep.
- R4: lowpwr_o is 1 in sleep while chip select is high and 0 in sleep while chip select is low; it is 0 outside sleep.
- R5: On entry to readout sdo_o carries bit 15 of the result; each later falling serial-clock edge moves it to the next lower bit.
- R6: The sixteenth falling serial-clock edge of a frame ends readout and starts exactly one new conversion.
- R7: A chip-select rise during readout aborts it and starts one new conversion; when it falls in the same synchronized cycle as a serial-clock fall, including the sixteenth, only one conversion starts.
- R8: sdo_oe_o is 1 when the synchronized chip select is low and 0 when it is high, and 0 throughout the power-on state.
- R9: With the output enabled, sdo_o is 1 during a conversion and 0 in sleep.
- R10: The result register takes the clamped core code on each core_valid_i during a conversion, the last one winning; a valid strobe outside a conversion leaves it unchanged.
- R11: core_raw_i is a two's-complement value of RAW_W bits; a negative value is stored as 0x0000, a value above 65535 as 0xFFFF, and any other value unchanged.
- R12: Reset clears the result register, so a conversion with no valid strobe reads back 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| core_raw_i | input | RAW_W | Signed code from the converter core |
| core_valid_i | input | 1 | One-cycle strobe marking core_raw_i valid |
| sdo_o | output | 1 | Serial data / busy bit |
| sdo_oe_o | output | 1 | Output enable of the three-state data driver |
| lowpwr_o | output | 1 | Low-power indication |
| conv_start_o | output | 1 | One-cycle pulse at the start of each conversion |

## Verification
Two pairs of events can share one synchronized cycle: a chip-select rise with an ordinary serial-clock fall in the middle of a frame, and a chip-select rise with the sixteenth fall. The bench drives both pins in the same time step, so both synchronizers flip together, and checks that exactly one conversion start is counted and that the following read returns the newly converted code. A third case holds chip select and the serial clock low while a conversion ends, and checks that the block goes straight through sleep into readout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_DATA  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int unsigned      N         = 2,
  parameter logic [N-1:0]     RST_VAL   = '1,
  parameter logic [N-1:0]     EDGE_RISE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {3{RST_VAL[g]}};
      else         sh_q <= {sh_q[1:0], pin_i[g]};
    end
    assign lvl_o[g] = sh_q[1];
    if (EDGE_RISE[g]) begin : g_rise
      assign edge_o[g] = sh_q[1] & ~sh_q[2];
    end else begin : g_fall
      assign edge_o[g] = ~sh_q[1] & sh_q[2];
    end
  end
endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int unsigned LEN = 16,
  localparam int unsigned CW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (en_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_code_clamp.sv
module adc_code_clamp #(
  parameter int unsigned RAW_W  = 18,
  parameter int unsigned CODE_W = 16
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [RAW_W-1:0] MAXV = RAW_W'((64'd1 << CODE_W) - 64'd1);

  always_comb begin
    if (raw_i[RAW_W-1])     code_o = '0;   // negative
    else if (raw_i > MAXV)  code_o = '1;   // over range
    else                    code_o = raw_i[CODE_W-1:0];
  end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int unsigned CODE_W = 16,
  localparam int unsigned IW = $clog2(CODE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              bit_o,
  output logic              last_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= IW'(CODE_W - 1);
    else if (shift_i) idx_q <= idx_q - 1'b1;
  end

  assign bit_o  = data_i[idx_q];
  assign last_o = (idx_q == '0);
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CODE_W   = 16,
  parameter int unsigned RAW_W    = 18,
  parameter int unsigned CONV_CYC = 1_660_000,
  parameter int unsigned POR_CYC  = 50_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic [RAW_W-1:0] core_raw_i,
  input  logic             core_valid_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             lowpwr_o,
  output logic             conv_start_o
);
  seq_state_e state_q, state_d;
  logic [1:0] pin_lvl, pin_edge;
  logic cs_lvl, sck_lvl, cs_rise, sck_fall;
  logic por_done, conv_done;
  logic [CODE_W-1:0] result_q, code_clamped;
  logic shift_bit, shift_last, shift_load, shift_step;
  logic start_q;

  // bit 0: chip select (rise detect), bit 1: serial clock (fall detect)
  adc_pin_sync #(.N(2), .RST_VAL(2'b11), .EDGE_RISE(2'b01)) u_sync (
    .clk_i, .rst_ni,
    .pin_i  ({sck_i, cs_ni}),
    .lvl_o  (pin_lvl),
    .edge_o (pin_edge)
  );
  assign cs_lvl   = pin_lvl[0];
  assign sck_lvl  = pin_lvl[1];
  assign cs_rise  = pin_edge[0];
  assign sck_fall = pin_edge[1];

  adc_cycle_timer #(.LEN(POR_CYC)) u_por_tmr (
    .clk_i, .rst_ni,
    .clr_i  (state_q != ST_POR),
    .en_i   (state_q == ST_POR),
    .done_o (por_done)
  );

  adc_cycle_timer #(.LEN(CONV_CYC)) u_conv_tmr (
    .clk_i, .rst_ni,
    .clr_i  (state_q != ST_CONV),
    .en_i   (state_q == ST_CONV),
    .done_o (conv_done)
  );

  adc_code_clamp #(.RAW_W(RAW_W), .CODE_W(CODE_W)) u_clamp (
    .raw_i  (core_raw_i),
    .code_o (code_clamped)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:   if (por_done)  state_d = ST_CONV;
      ST_CONV:  if (conv_done) state_d = ST_SLEEP;
      ST_SLEEP: if (!cs_lvl && !sck_lvl) state_d = ST_DATA;
      ST_DATA: begin
        if (cs_rise)                     state_d = ST_CONV;  // abort wins
        else if (sck_fall && shift_last) state_d = ST_CONV;
      end
      default: state_d = ST_POR;
    endcase
  end

  assign shift_load = (state_q == ST_SLEEP) && (state_d == ST_DATA);
  assign shift_step = (state_q == ST_DATA) && sck_fall && !cs_rise;

  adc_shift_out #(.CODE_W(CODE_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i  (shift_load),
    .shift_i (shift_step),
    .data_i  (result_q),
    .bit_o   (shift_bit),
    .last_o  (shift_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_POR;
      start_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      start_q <= (state_d == ST_CONV) && (state_q != ST_CONV);
      if (state_q == ST_CONV && core_valid_i) result_q <= code_clamped;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CONV: sdo_o = 1'b1;        // busy
      ST_DATA: sdo_o = shift_bit;
      default: sdo_o = 1'b0;
    endcase
  end

  assign sdo_oe_o     = !cs_lvl && (state_q != ST_POR);
  assign lowpwr_o     = (state_q == ST_SLEEP) && cs_lvl;
  assign conv_start_o = start_q;
endmodule

// File: rtl/adc_readout_seq_chk.sv
module adc_readout_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input seq_state_e        state_i,
  input logic              conv_done_i,
  input logic              cs_rise_i,
  input logic [CODE_W-1:0] result_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              lowpwr_o,
  input logic              conv_start_o
);
  a_r1_order_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_SLEEP |=> state_i inside {ST_SLEEP, ST_DATA});
  a_r1_order_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DATA |=> state_i inside {ST_DATA, ST_CONV});
  a_r2_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CONV && !conv_done_i) |=> state_i == ST_CONV);
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DATA && cs_rise_i) |=> (state_i == ST_CONV && conv_start_o));
  a_r1_start_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> state_i == ST_CONV);
  a_r4_lowpwr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_o |-> !sdo_oe_o);
  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CONV && sdo_oe_o) |-> sdo_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_SLEEP |=> $stable(result_i));
endmodule

bind adc_readout_seq adc_readout_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .conv_done_i  (conv_done),
  .cs_rise_i    (cs_rise),
  .result_i     (result_q),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .lowpwr_o     (lowpwr_o),
  .conv_start_o (conv_start_o)
);

// File: tb/adc_readout_seq_bench.sv
module adc_readout_seq_bench;
  localparam int CONV = 40;
  localparam int POR  = 12;
  localparam int RW   = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b1;
  logic [RW-1:0] raw = '0;
  logic valid = 1'b0;
  logic sdo, sdo_oe, lowpwr, conv_start;

  int checks = 0, fails = 0;
  int starts = 0, cyc = 0, last_start = 0;
  logic model_en = 1'b1;
  logic [RW-1:0] model_raw = '0;
  logic [RW-1:0] poke_raw = '0;
  int poke_req = 0, poke_ack = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_readout_seq #(.CODE_W(16), .RAW_W(RW), .CONV_CYC(CONV), .POR_CYC(POR)) u_adc_readout_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .core_raw_i(raw), .core_valid_i(valid),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .lowpwr_o(lowpwr), .conv_start_o(conv_start)
  );

  // core stub and start monitor
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      cyc++;
      valid = 1'b0;
      if (conv_start) begin
        starts++;
        last_start = cyc;
        if (model_en) dly = 3;
      end
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin raw = model_raw; valid = 1'b1; end
      end
      if (poke_req != poke_ack) begin
        raw = poke_raw; valid = 1'b1; poke_ack = poke_req;
      end
    end
  end

  function automatic logic [15:0] clamp(input logic [RW-1:0] r);
    if (r[RW-1]) return 16'h0000;
    if (r > 18'd65535) return 16'hFFFF;
    return r[15:0];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    cs_n = 1'b0; sck = 1'b1;
    tick(4);
    while (sdo_oe && sdo && n < 300) begin tick(1); n++; end
    check(sdo_oe && !sdo, tag, {sdo_oe, sdo}, 2'b10);
  endtask

  // read 16 bits, leave sck high after the last bit
  task automatic read_bits(output logic [15:0] w);
    sck = 1'b0; tick(5);
    for (int i = 15; i >= 0; i--) begin
      w[i] = sdo;
      sck = 1'b1; tick(4);
      if (i > 0) begin sck = 1'b0; tick(5); end
    end
  endtask

  task automatic full_read(input logic [RW-1:0] next_raw, input logic [15:0] exp, input string tag);
    logic [15:0] w;
    int s0;
    wait_ready(tag);
    read_bits(w);
    check(w == exp, tag, w, exp);
    model_raw = next_raw;
    s0 = starts;
    sck = 1'b0; tick(5);
    check(starts == s0 + 1, "R6 sixteenth fall starts conversion", starts - s0, 1);
    sck = 1'b1;
  endtask

  task automatic t_reset;
    int c = 0;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b1;
    model_raw = 18'h0A5C3;
    tick(3);
    check(!sdo_oe && !lowpwr && !conv_start, "R8 reset outputs idle", {sdo_oe, lowpwr, conv_start}, 0);
    rst_n = 1'b1;
    while (!conv_start && c < 200) begin
      tick(1); c++;
      if (c == POR / 2) check(!sdo_oe, "R8 driver off during power-on", sdo_oe, 0);
    end
    check(c >= POR && c <= POR + 1, "R1 power-on length", c, POR);
  endtask

  task automatic t_conv_len;
    int c = 0;
    while (sdo_oe && sdo && c < 300) begin tick(1); c++; end
    check(c >= CONV - 1 && c <= CONV + 1, "R2 conversion length", c, CONV);
    check(sdo_oe && !sdo, "R9 ready reads low in sleep", sdo, 0);
    check(!lowpwr, "R4 normal power with cs low", lowpwr, 0);
  endtask

  task automatic t_sleep_exit;
    logic [15:0] w;
    int s0;
    cs_n = 1'b1; sck = 1'b0; tick(6);
    check(lowpwr && !sdo_oe, "R4 low power with cs high", {lowpwr, sdo_oe}, 2'b10);
    sck = 1'b1; tick(3); cs_n = 1'b0; tick(30);
    check(!lowpwr && sdo_oe && !sdo, "R3 stays asleep with sck high", {lowpwr, sdo_oe, sdo}, 3'b010);
    poke_raw = 18'h01234; poke_req++;
    tick(3);
    read_bits(w);
    check(w == 16'hA5C3, "R5 msb-first readout", w, 16'hA5C3);
    check(w == 16'hA5C3, "R10 sleep valid ignored", w, 16'hA5C3);
    model_raw = 18'h3FFFB;   // -5
    s0 = starts;
    sck = 1'b0; tick(5);
    check(starts == s0 + 1, "R6 end of frame", starts - s0, 1);
    check(sdo_oe && sdo, "R9 busy during conversion", {sdo_oe, sdo}, 2'b11);
    sck = 1'b1;
  endtask

  task automatic t_clamp;
    full_read(18'h11170, clamp(18'h3FFFB), "R11 negative clamps to zero");
    full_read(18'h0FFFF, 16'hFFFF, "R11 over range clamps to full scale");
    full_read(18'h00000, 16'hFFFF, "R11 full scale passes");
    full_read(18'h0B00F, 16'h0000, "R11 zero passes");
  endtask

  task automatic t_abort;
    logic [15:0] w;
    int s0, len;
    wait_ready("R9 ready before abort");
    sck = 1'b0; tick(5);
    check(sdo == 1'b1, "R5 first bit after entry", sdo, 1);
    for (int i = 0; i < 4; i++) begin sck = 1'b1; tick(4); sck = 1'b0; tick(5); end
    model_raw = 18'h05A5A;
    s0 = starts;
    cs_n = 1'b1; tick(6);
    check(starts == s0 + 1, "R7 cs rise aborts", starts - s0, 1);
    check(!sdo_oe, "R8 driver off with cs high", sdo_oe, 0);
    for (int i = 0; i < 5; i++) begin
      cs_n = 1'b0; sck = 1'b0; tick(2); sck = 1'b1; tick(2); cs_n = 1'b1; tick(2);
    end
    cs_n = 1'b0; sck = 1'b1; tick(4);
    while (sdo && cyc - last_start < 300) tick(1);
    len = cyc - last_start;
    check(len >= CONV - 1 && len <= CONV + 1, "R2 pins cannot abort conversion", len, CONV);
    check(starts == s0 + 1, "R2 no restart from pin activity", starts - s0, 1);
    read_bits(w);
    check(w == 16'h5A5A, "R10 result from latest conversion", w, 16'h5A5A);
    model_raw = 18'h00F0F;
    sck = 1'b0; tick(5); sck = 1'b1;
  endtask

  task automatic t_simul;
    logic [15:0] w;
    int s0;
    wait_ready("R9 ready before coincident abort");
    sck = 1'b0; tick(5);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; tick(4); sck = 1'b0; tick(5); end
    sck = 1'b1; tick(4);
    model_raw = 18'h0C3C3;
    s0 = starts;
    cs_n = 1'b1; sck = 1'b0; tick(20);
    check(starts == s0 + 1, "R7 abort with sck fall", starts - s0, 1);
    wait_ready("R9 ready after coincident abort");
    read_bits(w);
    check(w == 16'hC3C3, "R7 new code after abort", w, 16'hC3C3);
    model_raw = 18'h00777;
    s0 = starts;
    cs_n = 1'b1; sck = 1'b0; tick(20);
    check(starts == s0 + 1, "R7 cs rise on sixteenth fall", starts - s0, 1);
    // keep pins low across the end of conversion
    cs_n = 1'b0; sck = 1'b0;
    tick(CONV + 10);
    check(sdo_oe && sdo == 1'b0, "R3 pass straight into readout bit15", sdo, 0);
    sck = 1'b1; tick(4); sck = 1'b0; tick(5);
    check(sdo == 1'b0, "R5 bit14", sdo, 0);
    cs_n = 1'b1; sck = 1'b1; tick(5);
  endtask

  task automatic t_por_clear;
    logic [15:0] w;
    model_en = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(POR + 4);
    wait_ready("R12 ready after reset");
    read_bits(w);
    check(w == 16'h0000, "R12 reset clears result", w, 0);
    model_en = 1'b1;
    sck = 1'b0; tick(5); cs_n = 1'b1; sck = 1'b1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_conv_len();
    t_sleep_exit();
    t_clamp();
    t_abort();
    t_simul();
    t_por_clear();
    finish_run();
  end
endmodule